// File: doc/BRIEF.md
# Trap Second-Value Register Writer

This block keeps the three second trap-value registers of a hart: one for traps handled in machine mode, one for traps handled in supervisor mode (HS or S), and one for traps handled in virtual-supervisor mode. When the trap logic signals that a trap is being taken, the block picks the register that belongs to the trap's target mode. It writes that register in the same clock edge. The value written depends on the kind of exception. A capability fault stores a pre-packed type/cause word. A load or store/AMO page fault stores a small code that says which page-table check failed. Every other exception writes zero, so stale information never survives into a later trap.

Software reads and writes the registers through a simple CSR port addressed by the usual 12-bit CSR number. A read is combinational. A write takes effect on the next clock edge. If a trap and a software write hit the same register in one cycle, the trap value wins. An option can tie the machine register to zero for implementations that do not report capability-fault detail there.

Top module: `trap_aux_info_wr`

## Requirements
- R1: After reset, all three registers read as zero.
- R2: The target-mode code selects the register. Code 3 selects the machine register, code 1 the supervisor register and code 2 the virtual-supervisor register. Code 0 selects none. A trap changes only the selected register, and the other two keep their value.
- R3: When the capability-fault flag is set during a trap, the selected register receives the fault word exactly. This holds even when page-fault flags are also set.
- R4: With no capability fault and exception code 13 or 15, the page-fault code is written. The code is 0 when only the normal page fault is flagged, 1 when only the capability page-table fault is flagged, and 2 when both are flagged.
- R5: A trap with no capability fault and any exception code other than 13 or 15 writes zero to the selected register, replacing any earlier value.
- R6: The page-fault flags have no effect when the exception code is not 13 or 15. Such a trap still writes zero.
- R7: The CSR addresses are 0x34b (machine), 0x14b (supervisor) and 0x24b (virtual supervisor). A read at one of these addresses returns that register in the same cycle.
- R8: A read at any other address returns zero and raises the illegal flag. A read at a mapped address keeps the illegal flag low.
- R9: A software write to a mapped address updates that register at the next clock edge. A write to an unmapped address changes no register.
- R10: When a trap and a software write target the same register in one cycle, the trap value is kept. A software write to a different register in that cycle still takes effect.
- R11: With the machine read-only option set, the machine register always reads zero. Traps and software writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_target | input | 2 | Target mode: 3 machine, 1 supervisor, 2 virtual supervisor, 0 none |
| trap_code | input | EXC_W | Exception code of the trap |
| cap_fault | input | 1 | The trap is a capability fault |
| cap_fault_info | input | XLEN | Pre-packed type/cause word for a capability fault |
| pf_normal | input | 1 | Normal page-table fault detected |
| pf_cap | input | 1 | Capability page-table fault detected |
| csr_addr | input | 12 | CSR address for read and write |
| csr_re | input | 1 | CSR read access |
| csr_we | input | 1 | CSR write access |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_illegal | output | 1 | Access to an address this block does not map |

## Verification
The assertions assume that the target-mode code and the flags only have meaning while trap_valid is high. They also assume that the capability fault word is stable during the trap cycle. Each trap-related property looks at the register one cycle after the trap and is conditioned on trap_valid and the exact target code. The stimulus changes inputs only just after a rising edge and holds them for one full cycle. It drops trap_valid and csr_we back to zero between operations, so every property sees isolated trap cycles, apart from the deliberate trap-plus-write collisions.

// File: rtl/trap_aux_pkg.sv
package trap_aux_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SUP  = 2'd1,
      TGT_VSUP = 2'd2,
      TGT_MACH = 2'd3
   } trap_tgt_e;

   localparam int unsigned SLOT_MACH = 0;
   localparam int unsigned SLOT_SUP  = 1;
   localparam int unsigned SLOT_VSUP = 2;
   localparam int unsigned NSLOT     = 3;

   localparam int unsigned EXC_LOAD_PF  = 13;
   localparam int unsigned EXC_STORE_PF = 15;

   localparam int unsigned PFC_NORMAL = 0;
   localparam int unsigned PFC_CAP    = 1;
   localparam int unsigned PFC_BOTH   = 2;
endpackage

// File: rtl/trap_aux_value.sv
module trap_aux_value
   import trap_aux_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned EXC_W = 6
) (
   input  logic [EXC_W-1:0] code,
   input  logic             cap_fault,
   input  logic [XLEN-1:0]  cap_info,
   input  logic             pf_normal,
   input  logic             pf_cap,
   output logic [XLEN-1:0]  value
);
   logic is_pf;
   logic [XLEN-1:0] pf_word;

   assign is_pf = (code == EXC_W'(EXC_LOAD_PF)) || (code == EXC_W'(EXC_STORE_PF));

   always_comb begin
      if (pf_normal && pf_cap)
         pf_word = XLEN'(PFC_BOTH);
      else if (pf_cap)
         pf_word = XLEN'(PFC_CAP);
      else
         pf_word = XLEN'(PFC_NORMAL);
   end

   always_comb begin
      if (cap_fault)
         value = cap_info;
      else if (is_pf)
         value = pf_word;
      else
         value = '0;
   end
endmodule

// File: rtl/trap_aux_slot.sv
module trap_aux_slot #(
   parameter int unsigned XLEN    = 64,
   parameter bit          RO_ZERO = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_we,
   input  logic [XLEN-1:0] trap_val,
   input  logic            sw_we,
   input  logic [XLEN-1:0] sw_val,
   output logic [XLEN-1:0] q
);
   generate
      if (RO_ZERO) begin : g_tied
         logic unused_tied;
         assign unused_tied = ^{clk, rst_n, trap_we, trap_val, sw_we, sw_val};
         assign q = '0;
      end else begin : g_reg
         logic [XLEN-1:0] q_r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q_r <= '0;
            else if (trap_we)
               q_r <= trap_val;
            else if (sw_we)
               q_r <= sw_val;
         end
         assign q = q_r;
      end
   endgenerate
endmodule

// File: rtl/trap_aux_info_wr.sv
module trap_aux_info_wr
   import trap_aux_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned EXC_W      = 6,
   parameter logic [11:0] ADDR_MACH  = 12'h34b,
   parameter logic [11:0] ADDR_SUP   = 12'h14b,
   parameter logic [11:0] ADDR_VSUP  = 12'h24b,
   parameter bit          M_CAP_RO   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_valid,
   input  logic [1:0]       trap_target,
   input  logic [EXC_W-1:0] trap_code,
   input  logic             cap_fault,
   input  logic [XLEN-1:0]  cap_fault_info,
   input  logic             pf_normal,
   input  logic             pf_cap,
   input  logic [11:0]      csr_addr,
   input  logic             csr_re,
   input  logic             csr_we,
   input  logic [XLEN-1:0]  csr_wdata,
   output logic [XLEN-1:0]  csr_rdata,
   output logic             csr_illegal
);
   localparam logic [NSLOT-1:0][11:0] SLOT_ADDR = {ADDR_VSUP, ADDR_SUP, ADDR_MACH};
   localparam logic [NSLOT-1:0][1:0]  SLOT_TGT  = {TGT_VSUP, TGT_SUP, TGT_MACH};

   if (XLEN < 8) begin : g_chk_xlen
      $error("trap_aux_info_wr: XLEN must be at least 8");
   end
   if (EXC_W < 4) begin : g_chk_exc
      $error("trap_aux_info_wr: EXC_W must hold code 15");
   end
   if (ADDR_MACH == ADDR_SUP || ADDR_MACH == ADDR_VSUP || ADDR_SUP == ADDR_VSUP) begin : g_chk_addr
      $error("trap_aux_info_wr: CSR addresses must differ");
   end

   logic [XLEN-1:0]             trap_val;
   logic [NSLOT-1:0]            hit;
   logic [NSLOT-1:0]            trap_sel;
   logic [NSLOT-1:0][XLEN-1:0]  slot_q;

   trap_aux_value #(.XLEN(XLEN), .EXC_W(EXC_W)) u_value (
      .code      (trap_code),
      .cap_fault (cap_fault),
      .cap_info  (cap_fault_info),
      .pf_normal (pf_normal),
      .pf_cap    (pf_cap),
      .value     (trap_val)
   );

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign hit[i]      = (csr_addr == SLOT_ADDR[i]);
      assign trap_sel[i] = trap_valid && (trap_target == SLOT_TGT[i]);

      trap_aux_slot #(
         .XLEN    (XLEN),
         .RO_ZERO ((i == SLOT_MACH) && M_CAP_RO)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .trap_we  (trap_sel[i]),
         .trap_val (trap_val),
         .sw_we    (csr_we && hit[i]),
         .sw_val   (csr_wdata),
         .q        (slot_q[i])
      );
   end

   always_comb begin
      csr_rdata = '0;
      for (int k = 0; k < NSLOT; k++)
         if (hit[k]) csr_rdata = slot_q[k];
   end

   assign csr_illegal = (csr_re || csr_we) && (hit == '0);
endmodule

// File: rtl/trap_aux_info_chk.sv
module trap_aux_info_chk
   import trap_aux_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned EXC_W     = 6,
   parameter logic [11:0] ADDR_MACH = 12'h34b,
   parameter logic [11:0] ADDR_SUP  = 12'h14b,
   parameter logic [11:0] ADDR_VSUP = 12'h24b
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       trap_valid,
   input logic [1:0]                 trap_target,
   input logic [EXC_W-1:0]           trap_code,
   input logic                       cap_fault,
   input logic [XLEN-1:0]            cap_fault_info,
   input logic                       pf_normal,
   input logic                       pf_cap,
   input logic [11:0]                csr_addr,
   input logic                       csr_re,
   input logic                       csr_we,
   input logic [XLEN-1:0]            csr_rdata,
   input logic                       csr_illegal,
   input logic [NSLOT-1:0][XLEN-1:0] slot_q
);
   logic pf_code;
   logic mapped;
   assign pf_code = (trap_code == EXC_W'(13)) || (trap_code == EXC_W'(15));
   assign mapped  = (csr_addr == ADDR_MACH) || (csr_addr == ADDR_SUP) || (csr_addr == ADDR_VSUP);

   // R2
   mach_trap_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_target == 2'd3 && !csr_we)
      |=> ($stable(slot_q[SLOT_SUP]) && $stable(slot_q[SLOT_VSUP])));

   // R3
   sup_cap_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_target == 2'd1 && cap_fault)
      |=> (slot_q[SLOT_SUP] == $past(cap_fault_info)));

   // R4
   vs_both_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_target == 2'd2 && !cap_fault && pf_code && pf_normal && pf_cap)
      |=> (slot_q[SLOT_VSUP] == XLEN'(2)));

   // R5
   vs_plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_target == 2'd2 && !cap_fault && !pf_code)
      |=> (slot_q[SLOT_VSUP] == '0));

   // R8
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_re && !mapped) |-> (csr_illegal && csr_rdata == '0));

   // R10
   trap_beats_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_target == 2'd1 && !cap_fault && !pf_code && csr_we && csr_addr == ADDR_SUP)
      |=> (slot_q[SLOT_SUP] == '0));
endmodule

bind trap_aux_info_wr trap_aux_info_chk #(
   .XLEN(XLEN), .EXC_W(EXC_W),
   .ADDR_MACH(ADDR_MACH), .ADDR_SUP(ADDR_SUP), .ADDR_VSUP(ADDR_VSUP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_target(trap_target),
   .trap_code(trap_code), .cap_fault(cap_fault), .cap_fault_info(cap_fault_info),
   .pf_normal(pf_normal), .pf_cap(pf_cap), .csr_addr(csr_addr), .csr_re(csr_re),
   .csr_we(csr_we), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .slot_q(slot_q)
);

// File: tb/trap_aux_info_wr_test.sv
`timescale 1ns/1ps
module trap_aux_info_wr_test;
   localparam int XLEN  = 64;
   localparam int EXC_W = 6;
   localparam logic [11:0] AM = 12'h34b;
   localparam logic [11:0] AS = 12'h14b;
   localparam logic [11:0] AV = 12'h24b;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trap_valid = 1'b0;
   logic [1:0]       trap_target = '0;
   logic [EXC_W-1:0] trap_code = '0;
   logic             cap_fault = 1'b0;
   logic [XLEN-1:0]  cap_fault_info = '0;
   logic             pf_normal = 1'b0;
   logic             pf_cap = 1'b0;
   logic [11:0]      csr_addr = '0;
   logic             csr_re = 1'b0;
   logic             csr_we = 1'b0;
   logic [XLEN-1:0]  csr_wdata = '0;
   logic [XLEN-1:0]  rdata_a, rdata_b;
   logic             ill_a, ill_b;

   always #4 clk = ~clk;

   trap_aux_info_wr #(.XLEN(XLEN), .EXC_W(EXC_W)) uut (
      .clk, .rst_n, .trap_valid, .trap_target, .trap_code, .cap_fault, .cap_fault_info,
      .pf_normal, .pf_cap, .csr_addr, .csr_re, .csr_we, .csr_wdata,
      .csr_rdata(rdata_a), .csr_illegal(ill_a));

   trap_aux_info_wr #(.XLEN(XLEN), .EXC_W(EXC_W), .M_CAP_RO(1'b1)) uut_ro (
      .clk, .rst_n, .trap_valid, .trap_target, .trap_code, .cap_fault, .cap_fault_info,
      .pf_normal, .pf_cap, .csr_addr, .csr_re, .csr_we, .csr_wdata,
      .csr_rdata(rdata_b), .csr_illegal(ill_b));

   typedef struct {
      logic [XLEN-1:0] exp_a;
      logic [XLEN-1:0] exp_b;
      logic            exp_ill;
      string           req;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   logic [XLEN-1:0] sh_m = '0, sh_s = '0, sh_v = '0;

   function automatic logic [XLEN-1:0] model_val(int code, bit cf, logic [XLEN-1:0] info, bit pn, bit pc);
      if (cf) return info;
      if (code == 13 || code == 15) return (pn && pc) ? XLEN'(2) : (pc ? XLEN'(1) : XLEN'(0));
      return '0;
   endfunction

   task automatic step(bit tv, logic [1:0] tgt, int code, bit cf, logic [XLEN-1:0] info,
                       bit pn, bit pc, bit we, logic [11:0] wa, logic [XLEN-1:0] wd);
      logic [XLEN-1:0] v;
      @(posedge clk); #1;
      trap_valid = tv; trap_target = tgt; trap_code = EXC_W'(code);
      cap_fault = cf; cap_fault_info = info; pf_normal = pn; pf_cap = pc;
      csr_we = we; csr_addr = wa; csr_wdata = wd;
      v = model_val(code, cf, info, pn, pc);
      if (we && wa == AM && !(tv && tgt == 2'd3)) sh_m = wd;
      if (we && wa == AS && !(tv && tgt == 2'd1)) sh_s = wd;
      if (we && wa == AV && !(tv && tgt == 2'd2)) sh_v = wd;
      if (tv && tgt == 2'd3) sh_m = v;
      if (tv && tgt == 2'd1) sh_s = v;
      if (tv && tgt == 2'd2) sh_v = v;
      @(posedge clk); #1;
      trap_valid = 1'b0; csr_we = 1'b0; cap_fault = 1'b0; pf_normal = 1'b0; pf_cap = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, string req);
      item_t it;
      @(posedge clk); #1;
      csr_re = 1'b1; csr_addr = a;
      it.exp_ill = !(a == AM || a == AS || a == AV);
      it.exp_a = (a == AM) ? sh_m : (a == AS) ? sh_s : (a == AV) ? sh_v : '0;
      it.exp_b = (a == AM) ? '0 : it.exp_a;
      it.req = req;
      sb.push_back(it);
      @(posedge clk); #1;
      csr_re = 1'b0;
   endtask

   task automatic rd_all(string req);
      rd(AM, req); rd(AS, req); rd(AV, req);
   endtask

   always @(negedge clk) begin
      if (csr_re && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata_a !== it.exp_a || ill_a !== it.exp_ill) begin
            errors++;
            $display("FAIL %s addr=%h data=%h ill=%b expected data=%h ill=%b",
                     it.req, csr_addr, rdata_a, ill_a, it.exp_a, it.exp_ill);
         end
         checks++;
         if (rdata_b !== it.exp_b) begin
            errors++;
            $display("FAIL %s (ro variant) addr=%h data=%h expected %h",
                     it.req, csr_addr, rdata_b, it.exp_b);
         end
      end
   end

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd_all("R1 reset zero");
      rd(12'h000, "R8 unmapped read");
      rd(12'h34c, "R8 unmapped read near");
      // R9 software write, R11 ro variant ignores it
      step(0, 2'd0, 0, 0, '0, 0, 0, 1, AM, 64'hA5A5_0000_1111_2222);
      rd(AM, "R9 R11 sw write machine");
      step(0, 2'd0, 0, 0, '0, 0, 0, 1, 12'h123, 64'hDEAD);
      rd_all("R9 unmapped write no effect");
      // R3 capability word wins over page flags
      step(1, 2'd1, 13, 1, 64'h0000_1234_0000_0005, 1, 1, 0, '0, '0);
      rd_all("R3 R2 cap fault into supervisor");
      // R4 page-fault codes
      step(0, 2'd0, 0, 0, '0, 0, 0, 1, AV, 64'hFF);
      step(1, 2'd2, 13, 0, '0, 1, 0, 0, '0, '0);
      rd(AV, "R4 normal only -> 0");
      step(1, 2'd2, 15, 0, '0, 0, 1, 0, '0, '0);
      rd(AV, "R4 cap pte only -> 1");
      step(1, 2'd2, 13, 0, '0, 1, 1, 0, '0, '0);
      rd_all("R4 both -> 2");
      // R6 flags ignored on access fault, R11 trap into tied register
      step(1, 2'd3, 5, 0, '0, 1, 1, 0, '0, '0);
      rd_all("R6 R11 access fault clears machine");
      // R5 plain exception clears supervisor
      step(1, 2'd1, 2, 0, '0, 0, 0, 0, '0, '0);
      rd_all("R5 plain exception clears");
      // R2 target none
      step(1, 2'd0, 0, 1, 64'h55, 0, 0, 0, '0, '0);
      rd_all("R2 target none writes nothing");
      // R10 collisions
      step(1, 2'd1, 0, 1, 64'h77, 0, 0, 1, AS, 64'h55);
      rd(AS, "R10 trap beats sw write");
      step(1, 2'd2, 0, 1, 64'h99, 0, 0, 1, AM, 64'h66);
      rd_all("R10 sw write other register proceeds");
      step(1, 2'd1, 7, 0, '0, 0, 0, 1, AS, 64'h44);
      rd(AS, "R10 R7 trap zero beats sw write");
      rd(AV, "R7 read virtual supervisor");
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule